// File: doc/BRIEF.md
# Dual Parallel Port I/O Group

This block provides 48 general-purpose digital lines behind a small 8-bit host bus. The lines are arranged as two identical groups, each with three 8-bit ports (A, B and C) and one control register. Every port latches what the host writes, and the latch is driven onto the pins only where the port is set as an output. A host read of a data port samples the live pin levels at the read strobe.

Direction is chosen per group by a mode-set control word. Ports A and B switch as whole bytes, while port C switches as two independent nibbles. A second form of control word sets or clears a single port C bit without touching the direction. Only the basic latched mode is built. Pins appear as separate input, output and output-enable vectors, so a pad ring or a bench can close the loop.

Top module: `dual_pio_bank`

## Requirements
- R1: While reset is low and after it is released, every output-enable is 0, every output latch is 0, and the read data register is 0.
- R2: Address offsets 0, 1 and 2 select ports A, B and C of group 0, and offset 3 selects its control register. Offsets 4, 5, 6 and 7 select the same items of group 1. Port p of group g sits on pins `[24*g + 8*p +: 8]`.
- R3: A write to a data port loads the byte into that port's latch, and the latch shows on `pin_out` in the cycle after the write strobe.
- R4: A control write with bit 7 = 1 is a mode-set word. Bit 4 = 1 makes port A an input, bit 1 makes port B an input, bit 3 makes port C bits 7:4 inputs and bit 0 makes port C bits 3:0 inputs. A 0 in any of these bits makes that field an output.
- R5: A mode-set write clears all three latches of its own group to 0 and leaves the other group unchanged.
- R6: A control write with bit 7 = 0 sets port C bit `wdata[3:1]` of that group to `wdata[0]`. The other port C bits and all directions stay unchanged.
- R7: A read of a data port loads the 8 pin levels of that port into `bus_rdata` in the cycle after the read strobe. `bus_rdata` holds its value while no read is strobed.
- R8: A read of either control register, or of any offset from 8 to 15, returns 0xFF.
- R9: Each output-enable bit is the inverse of its direction bit. A write to a port set as input still updates its latch on `pin_out`, but the port's output-enable stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 4 | Byte offset in the 16-byte window |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_rdata | output | 8 | Registered read data |
| pin_in | input | 48 | Live pin levels |
| pin_out | output | 48 | Output latch values |
| pin_oe | output | 48 | Per-pin output enable, 1 = driven |

## Verification
The bench builds the block with its default of two groups, so the whole 16-byte window is in use. The bench can therefore show that the decode keeps the groups apart: a mode-set on one group clears that group's latches while the other keeps its values. It can also show that the upper eight offsets read back as 0xFF. With both groups present, a single run can exercise every nibble of the port C direction split and the bit command on group 1.

// File: rtl/pio_pkg.sv
// pio_pkg: shared constants and helpers for the dual parallel port block.
// Assumes 8-bit ports and three ports plus one control register per group.
package pio_pkg;
    localparam int PORT_W   = 8;
    localparam int PORTS    = 3;
    localparam int GRP_PINS = PORT_W * PORTS;

    // Control word bit positions (the host encodes these).
    localparam int CW_MODE  = 7;
    localparam int CW_A_IN  = 4;
    localparam int CW_CU_IN = 3;
    localparam int CW_B_IN  = 1;
    localparam int CW_CL_IN = 0;

    // Direction state of one group, 1 = input.
    typedef struct packed {
        logic a;
        logic b;
        logic cu;
        logic cl;
    } dir_t;

    localparam dir_t DIR_ALL_IN = '{a: 1'b1, b: 1'b1, cu: 1'b1, cl: 1'b1};

    // Expand a direction set to per-pin output enables, A in the low byte.
    function automatic logic [GRP_PINS-1:0] dir_to_oe(input dir_t d);
        return {{4{~d.cu}}, {4{~d.cl}}, {8{~d.b}}, {8{~d.a}}};
    endfunction
endpackage

// File: rtl/pio_addr_decode.sv
// pio_addr_decode: splits a window offset into group and item, and raises
// one-hot write enables. Assumes four offsets per group, item 3 = control.
module pio_addr_decode
    import pio_pkg::*;
#(
    parameter int GROUPS = 2,
    parameter int ADDR_W = 4,
    localparam int GSEL_W = (GROUPS > 1) ? $clog2(GROUPS) : 1
) (
    input  logic [ADDR_W-1:0]              addr,
    input  logic                           wr,
    output logic [GROUPS-1:0][PORTS-1:0]   port_we,
    output logic [GROUPS-1:0]              ctl_we,
    output logic                           data_hit,
    output logic [GSEL_W-1:0]              sel_grp,
    output logic [1:0]                     sel_item
);
    logic [ADDR_W-3:0] grp_idx;
    logic              grp_ok;

    assign grp_idx  = addr[ADDR_W-1:2];
    assign sel_item = addr[1:0];
    assign sel_grp  = GSEL_W'(grp_idx);

    // Purpose: decide whether the offset falls on an existing group.
    always_comb begin
        grp_ok = (int'(grp_idx) < GROUPS);
    end

    assign data_hit = grp_ok && (sel_item != 2'd3);

    for (genvar g = 0; g < GROUPS; g++) begin : g_we
        logic here;
        assign here      = wr && (grp_idx == (ADDR_W-2)'(g));
        assign ctl_we[g] = here && (sel_item == 2'd3);
        for (genvar p = 0; p < PORTS; p++) begin : g_port
            assign port_we[g][p] = here && (sel_item == 2'(p));
        end
    end
endmodule

// File: rtl/pio_group.sv
// pio_group: one group of three latched ports with its direction state.
// Handles data writes, mode-set words and single-bit port C commands.
// Assumes at most one write enable is active per cycle.
module pio_group
    import pio_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [PORTS-1:0]     port_we,
    input  logic                 ctl_we,
    input  logic [PORT_W-1:0]    wdata,
    output logic [GRP_PINS-1:0]  lat_out,
    output logic [GRP_PINS-1:0]  lat_oe
);
    logic [PORT_W-1:0] lat_a, lat_b, lat_c;
    dir_t              dir_q;

    // Purpose: hold the direction set, reloaded only by a mode-set word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q <= DIR_ALL_IN;
        end else if (ctl_we && wdata[CW_MODE]) begin
            dir_q.a  <= wdata[CW_A_IN];
            dir_q.b  <= wdata[CW_B_IN];
            dir_q.cu <= wdata[CW_CU_IN];
            dir_q.cl <= wdata[CW_CL_IN];
        end
    end

    // Purpose: ports A and B latch host data, cleared by a mode-set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_a <= '0;
            lat_b <= '0;
        end else if (ctl_we && wdata[CW_MODE]) begin
            lat_a <= '0;
            lat_b <= '0;
        end else begin
            if (port_we[0]) lat_a <= wdata;
            if (port_we[1]) lat_b <= wdata;
        end
    end

    // Purpose: port C latch with byte write, mode-set clear and bit command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_c <= '0;
        end else if (ctl_we) begin
            if (wdata[CW_MODE]) lat_c <= '0;
            else                lat_c[wdata[3:1]] <= wdata[0];
        end else if (port_we[2]) begin
            lat_c <= wdata;
        end
    end

    assign lat_out = {lat_c, lat_b, lat_a};
    assign lat_oe  = dir_to_oe(dir_q);
endmodule

// File: rtl/pio_read_mux.sv
// pio_read_mux: picks the pin byte addressed by the host. Returns all ones
// for control registers and offsets without a group.
module pio_read_mux
    import pio_pkg::*;
#(
    parameter int GROUPS = 2,
    localparam int GSEL_W = (GROUPS > 1) ? $clog2(GROUPS) : 1,
    localparam int PINS   = GROUPS * GRP_PINS
) (
    input  logic [PINS-1:0]    pins,
    input  logic               data_hit,
    input  logic [GSEL_W-1:0]  sel_grp,
    input  logic [1:0]         sel_item,
    output logic [PORT_W-1:0]  rd_byte
);
    // Purpose: select one port byte, defaulting to 0xFF.
    always_comb begin
        rd_byte = '1;
        for (int g = 0; g < GROUPS; g++) begin
            for (int p = 0; p < PORTS; p++) begin
                if (data_hit && sel_grp == GSEL_W'(g) && sel_item == 2'(p))
                    rd_byte = pins[g*GRP_PINS + p*PORT_W +: PORT_W];
            end
        end
    end
endmodule

// File: rtl/dual_pio_bank.sv
// dual_pio_bank: top of the dual parallel port block. Decodes the host bus,
// instantiates one pio_group per group and registers read data on a strobe.
// Assumes single-cycle strobes and a 16-byte window (GROUPS <= 4).
module dual_pio_bank
    import pio_pkg::*;
#(
    parameter int GROUPS = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [3:0]  bus_addr,
    input  logic [7:0]  bus_wdata,
    input  logic        bus_wr,
    input  logic        bus_rd,
    output logic [7:0]  bus_rdata,
    input  logic [GROUPS*GRP_PINS-1:0] pin_in,
    output logic [GROUPS*GRP_PINS-1:0] pin_out,
    output logic [GROUPS*GRP_PINS-1:0] pin_oe
);
    localparam int ADDR_W = 4;
    localparam int GSEL_W = (GROUPS > 1) ? $clog2(GROUPS) : 1;

    logic [GROUPS-1:0][PORTS-1:0] port_we;
    logic [GROUPS-1:0]            ctl_we;
    logic                         data_hit;
    logic [GSEL_W-1:0]            sel_grp;
    logic [1:0]                   sel_item;
    logic [PORT_W-1:0]            rd_byte;

    pio_addr_decode #(.GROUPS(GROUPS), .ADDR_W(ADDR_W)) u_dec (
        .addr     (bus_addr),
        .wr       (bus_wr),
        .port_we  (port_we),
        .ctl_we   (ctl_we),
        .data_hit (data_hit),
        .sel_grp  (sel_grp),
        .sel_item (sel_item)
    );

    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
        pio_group u_grp (
            .clk     (clk),
            .rst_n   (rst_n),
            .port_we (port_we[g]),
            .ctl_we  (ctl_we[g]),
            .wdata   (bus_wdata),
            .lat_out (pin_out[g*GRP_PINS +: GRP_PINS]),
            .lat_oe  (pin_oe[g*GRP_PINS +: GRP_PINS])
        );
    end

    pio_read_mux #(.GROUPS(GROUPS)) u_rmux (
        .pins     (pin_in),
        .data_hit (data_hit),
        .sel_grp  (sel_grp),
        .sel_item (sel_item),
        .rd_byte  (rd_byte)
    );

    // Purpose: sample the selected byte on a read strobe, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_byte;
    end
endmodule

// File: rtl/pio_bank_checker.sv
// pio_bank_checker: protocol properties of dual_pio_bank, watched at its
// ports. Bound to every instance of the top module.
module pio_bank_checker #(
    parameter int GROUPS = 2,
    localparam int PINS = GROUPS * 24
) (
    input logic            clk,
    input logic            rst_n,
    input logic [3:0]      bus_addr,
    input logic [7:0]      bus_wdata,
    input logic            bus_wr,
    input logic            bus_rd,
    input logic [7:0]      bus_rdata,
    input logic [PINS-1:0] pin_out,
    input logic [PINS-1:0] pin_oe
);
    // R1: reset leaves nothing driven and all latches clear.
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (pin_oe == '0 && pin_out == '0 && bus_rdata == 8'h00));

    // R3: a port A write of group 0 appears on its pins next cycle.
    a_r3_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 4'd0) |=> (pin_out[7:0] == $past(bus_wdata)));

    // R5: a mode-set on group 0 clears its latches.
    a_r5_modeset_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 4'd3 && bus_wdata[7]) |=> (pin_out[23:0] == '0));

    // R6: a bit command leaves the group 0 direction alone.
    a_r6_bitcmd_keeps_dir: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 4'd3 && !bus_wdata[7]) |=> $stable(pin_oe[23:0]));

    // R7: read data holds without a strobe.
    a_r7_rdata_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));

    // R8: control register reads return all ones.
    a_r8_ctl_reads_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr[1:0] == 2'd3) |=> (bus_rdata == 8'hFF));
endmodule

bind dual_pio_bank pio_bank_checker #(.GROUPS(GROUPS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_rdata (bus_rdata),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe)
);

// File: tb/test_dual_pio_bank.sv
`timescale 1ns/1ps
module test_dual_pio_bank;
    localparam int PINS = 48;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [3:0]      bus_addr = '0;
    logic [7:0]      bus_wdata = '0;
    logic            bus_wr = 1'b0;
    logic            bus_rd = 1'b0;
    logic [7:0]      bus_rdata;
    logic [PINS-1:0] pin_in = '0;
    logic [PINS-1:0] pin_out, pin_oe;

    int total = 0;
    int bad = 0;
    logic done = 1'b0;

    // Requirement model, built from the brief only.
    logic [PINS-1:0] m_out = '0;
    logic [PINS-1:0] m_oe  = '0;

    // Scoreboard of expected read bytes with their requirement tags.
    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic       rd_seen = 1'b0;

    always #10 clk = ~clk;

    dual_pio_bank i_dual_pio_bank (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    task automatic check48(input string tag, input logic [PINS-1:0] act,
                           input logic [PINS-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_pins(input string tag);
        @(negedge clk);
        check48({tag, " out"}, pin_out, m_out);
        check48({tag, " oe"}, pin_oe, m_oe);
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [7:0] d);
        int g;
        @(posedge clk); #2;
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); #2;
        bus_wr = 1'b0;
        g = a / 4;
        if (a < 8) begin
            if (a % 4 != 3) begin
                m_out[g*24 + (a%4)*8 +: 8] = d;
            end else if (d[7]) begin
                m_out[g*24 +: 24] = '0;
                m_oe[g*24 +: 8]       = {8{~d[4]}};
                m_oe[g*24 + 8 +: 8]   = {8{~d[1]}};
                m_oe[g*24 + 16 +: 4]  = {4{~d[0]}};
                m_oe[g*24 + 20 +: 4]  = {4{~d[3]}};
            end else begin
                m_out[g*24 + 16 + int'(d[3:1])] = d[0];
            end
        end
    endtask

    // Driver: strobe a read and push the expected byte to the scoreboard.
    task automatic bus_read(input logic [3:0] a, input logic [7:0] exp,
                            input string tag);
        @(posedge clk); #2;
        bus_addr = a; bus_rd = 1'b1;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(posedge clk); #2;
        bus_rd = 1'b0;
        @(negedge clk);
    endtask

    // Monitor: note the edge that captured a read strobe.
    always @(posedge clk) rd_seen <= bus_rd && rst_n;

    // Monitor: compare the registered read byte half a cycle later.
    always @(negedge clk) begin
        if (rd_seen) begin
            logic [7:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            total++;
            if (bus_rdata !== e) begin
                bad++;
                $display("FAIL %s actual=%h expected=%h", t, bus_rdata, e);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        // R1: state while held in reset.
        @(negedge clk);
        check48("R1 out", pin_out, '0);
        check48("R1 oe", pin_oe, '0);
        check48("R1 rdata", {40'd0, bus_rdata}, '0);
        @(posedge clk); #2; rst_n = 1'b1;
        check_pins("R1 after release");

        // R4: all outputs on both groups.
        bus_write(4'd3, 8'h80);
        bus_write(4'd7, 8'h80);
        check_pins("R4 all outputs");

        // R2, R3: distinct byte per port.
        bus_write(4'd0, 8'h5A);
        check_pins("R3 port A0 write");
        bus_write(4'd1, 8'hC3);
        bus_write(4'd2, 8'h96);
        bus_write(4'd4, 8'h11);
        bus_write(4'd5, 8'h22);
        bus_write(4'd6, 8'h33);
        check_pins("R2 map of six ports");

        // R5: mode-set on group 0 leaves group 1 latches.
        bus_write(4'd3, 8'h80);
        check_pins("R5 group0 cleared, group1 kept");

        // R4: each direction bit alone.
        bus_write(4'd3, 8'h90);
        check_pins("R4 A input");
        bus_write(4'd3, 8'h82);
        check_pins("R4 B input");
        bus_write(4'd3, 8'h88);
        check_pins("R4 C upper input");
        bus_write(4'd3, 8'h81);
        check_pins("R4 C lower input");

        // R6: bit commands on group 1 port C (0x33 -> set 7 -> clear 1).
        bus_write(4'd7, 8'h0F);
        check_pins("R6 set C1 bit7");
        bus_write(4'd7, 8'h02);
        check_pins("R6 clear C1 bit1");
        check48("R6 C1 value", {40'd0, pin_out[47:40]}, {40'd0, 8'hB1});

        // R9: group 0 all inputs, write still lands in the latch.
        bus_write(4'd3, 8'h9B);
        bus_write(4'd0, 8'hAA);
        check_pins("R9 write to input port");

        // R7: reads of live pins per port.
        pin_in = 48'hF0E1_D2C3_B4A5;
        bus_read(4'd0, 8'hA5, "R7 read A0");
        bus_read(4'd1, 8'hB4, "R7 read B0");
        bus_read(4'd2, 8'hC3, "R7 read C0");
        bus_read(4'd4, 8'hD2, "R2 read A1");
        bus_read(4'd5, 8'hE1, "R2 read B1");
        bus_read(4'd6, 8'hF0, "R2 read C1");
        pin_in = 48'h0;
        repeat (2) @(negedge clk);
        check48("R7 rdata holds", {40'd0, bus_rdata}, {40'd0, 8'hF0});

        // R8: control and undecoded offsets.
        bus_read(4'd3, 8'hFF, "R8 ctl0 read");
        bus_read(4'd0, 8'h00, "R7 read zero");
        bus_read(4'd7, 8'hFF, "R8 ctl1 read");
        bus_read(4'd8, 8'hFF, "R8 offset 8");
        bus_read(4'd15, 8'hFF, "R8 offset 15");

        // R8: writes above offset 7 change nothing.
        bus_write(4'd9, 8'h55);
        check_pins("R8 write offset 9 ignored");

        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule